// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds four 32-bit event counters with the control state that steers them. Each counter has two local control registers, and one global control register sits above all of them. On every clock the bank sees a vector of 128 single-cycle event pulses. Each counter watches the pulse its local "a" register selects and adds one for every cycle in which that pulse is high, unless something stops it. A counter can be stopped by the global freeze, by its own local freeze, or by a mode mask in its local "b" register that blocks counting in supervisor mode or in user mode.

Software reaches the registers through a 10-bit register number that arrives as two 5-bit halves, together with a valid strobe, a write strobe, write data and a mode input. Read data and the two exception flags are combinational for the access presented in that cycle. A write takes effect at the next clock edge. Supervisor code may read and write every supervisor register. Every register also has a read-only user alias that any mode may read. A level interrupt request goes high when the global interrupt enable is set and some counter with its condition enable set has bit 31 high.

The run state of the bank is a two-state machine. In ST_RUN the counters may advance; in ST_HALT none does. There are three transitions. FREEZE_WR goes from ST_RUN to ST_HALT when software writes global bit 0 as 1. OVF_TRIP goes from ST_RUN to ST_HALT when freeze-on-overflow is set and any counter has bit 31 high. THAW_WR goes from ST_HALT to ST_RUN when software writes global bit 0 as 0. Global bit 0 reads back as 1 exactly when the machine is in ST_HALT.

Top module: `pmon_bank`

## Requirements
- R1: After reset every counter, every local "a" and "b" register and the global register read 0. The interrupt request and both exception flags are 0.
- R2: The register number is {pmr_first, pmr_second}, with pmr_first supplying bits 9:5. The supervisor numbers are: counters 0–3 at 16–19, local "a" at 144–147, local "b" at 288–291, global at 400.
- R3: A counter whose local "a" bits 6:0 select event k adds exactly one at each clock edge where events[k] is high and the counter is allowed to count.
- R4: Global bit 0 (freeze-all) set stops every counter. Local "a" bit 7 set stops only its own counter.
- R5: Local "b" bit 0 set blocks counting while user_mode is 0. Local "b" bit 1 set blocks counting while user_mode is 1.
- R6: The user aliases are 16 below their supervisor numbers (counters 0–3, "a" at 128–131, "b" at 272–275, global at 384). They return the same value as the supervisor number in either mode.
- R7: When user_mode is 1, any access to a supervisor number raises priv_exc. Such an access returns rdata 0 and changes no state.
- R8: A write to a user alias, or any access to an unmapped number, raises illegal_exc. Such an access returns rdata 0 and changes no state.
- R9: pm_irq equals global bit 1 AND (some counter has local "a" bit 8 set and counter bit 31 equal to 1). It falls once that counter is written below 2^31.
- R10: With global bit 2 (freeze-on-overflow) set, no counter advances after any counter's bit 31 becomes 1. Global bit 0 then reads 1.
- R11: A supervisor write to a counter in the same cycle as its selected event loads exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| user_mode | input | 1 | 1 for user mode, 0 for supervisor mode; used for access checks and count masks |
| pmr_first | input | 5 | Register number bits 9:5 |
| pmr_second | input | 5 | Register number bits 4:0 |
| wdata | input | 32 | Write data |
| events | input | 128 | Event pulses, one bit per event |
| rdata | output | 32 | Read data for the access presented this cycle, 0 if the access is refused |
| priv_exc | output | 1 | Supervisor register accessed in user mode |
| illegal_exc | output | 1 | Write to a user alias, or access to an unmapped number |
| pm_irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is the overflow trip. A counter must reach bit 31 while others keep counting, and it must be shown that nothing advances afterwards. The bench gets there by writing a counter to 0x7FFFFFFF and then driving its event together with another counter's event for several cycles. It expects exactly one increment on each and a global read of freeze-all as 1. The access rules are covered by sweeping all 1024 register numbers in both modes for reads, and in both modes for writes. After the write sweep, a full readback confirms that no refused write reached any register.

// File: rtl/pmon_pkg.sv
`timescale 1ns/1ps
package pmon_pkg;
    localparam int NUM_CNT   = 4;
    localparam int CNT_W     = 32;
    localparam int NUM_EVT   = 128;
    localparam int SEL_W     = $clog2(NUM_EVT);
    localparam int IDX_W     = $clog2(NUM_CNT);
    localparam int HALF_W    = 5;
    localparam int PMR_W     = 2 * HALF_W;
    localparam int ALIAS_GAP = 16;

    localparam int CNT_SUP = 16;
    localparam int LCA_SUP = 144;
    localparam int LCB_SUP = 288;
    localparam int GLB_SUP = 400;

    localparam int GLB_FRZ_BIT = 0;
    localparam int GLB_IE_BIT  = 1;
    localparam int GLB_FOV_BIT = 2;
    localparam int LCA_W       = SEL_W + 2;
    localparam int LCB_W       = 2;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CNT,
        RG_LCA,
        RG_LCB,
        RG_GLB
    } pm_region_e;

    typedef struct packed {
        pm_region_e             region;
        logic [IDX_W-1:0]       idx;
        logic                   user_alias;
    } pm_dec_t;

    typedef struct packed {
        logic             ce;
        logic             lfrz;
        logic [SEL_W-1:0] sel;
    } pm_lca_t;

    typedef struct packed {
        logic mask_u;
        logic mask_s;
    } pm_lcb_t;

    typedef enum logic {
        ST_RUN,
        ST_HALT
    } pm_run_e;
endpackage

// File: rtl/pmon_decode.sv
`timescale 1ns/1ps
module pmon_decode
    import pmon_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             user_mode,
    input  logic [PMR_W-1:0] pmr_num,
    output pm_dec_t          dec,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             priv_exc,
    output logic             illegal_exc
);
    logic mapped;

    always_comb begin
        dec = '{region: RG_NONE, idx: '0, user_alias: 1'b0};
        for (int i = 0; i < NUM_CNT; i++) begin
            if (pmr_num == PMR_W'(CNT_SUP + i)) begin
                dec.region = RG_CNT; dec.idx = IDX_W'(i); dec.user_alias = 1'b0;
            end
            if (pmr_num == PMR_W'(CNT_SUP - ALIAS_GAP + i)) begin
                dec.region = RG_CNT; dec.idx = IDX_W'(i); dec.user_alias = 1'b1;
            end
            if (pmr_num == PMR_W'(LCA_SUP + i)) begin
                dec.region = RG_LCA; dec.idx = IDX_W'(i); dec.user_alias = 1'b0;
            end
            if (pmr_num == PMR_W'(LCA_SUP - ALIAS_GAP + i)) begin
                dec.region = RG_LCA; dec.idx = IDX_W'(i); dec.user_alias = 1'b1;
            end
            if (pmr_num == PMR_W'(LCB_SUP + i)) begin
                dec.region = RG_LCB; dec.idx = IDX_W'(i); dec.user_alias = 1'b0;
            end
            if (pmr_num == PMR_W'(LCB_SUP - ALIAS_GAP + i)) begin
                dec.region = RG_LCB; dec.idx = IDX_W'(i); dec.user_alias = 1'b1;
            end
        end
        if (pmr_num == PMR_W'(GLB_SUP)) begin
            dec.region = RG_GLB; dec.user_alias = 1'b0;
        end
        if (pmr_num == PMR_W'(GLB_SUP - ALIAS_GAP)) begin
            dec.region = RG_GLB; dec.user_alias = 1'b1;
        end
    end

    always_comb begin
        mapped      = (dec.region != RG_NONE);
        priv_exc    = acc_valid && mapped && !dec.user_alias && user_mode;
        illegal_exc = acc_valid && (!mapped || (acc_write && dec.user_alias));
        rd_ok       = acc_valid && !acc_write && mapped && (dec.user_alias || !user_mode);
        wr_ok       = acc_valid && acc_write && mapped && !dec.user_alias && !user_mode;
    end
endmodule

// File: rtl/pmon_counter.sv
`timescale 1ns/1ps
module pmon_counter
    import pmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               user_mode,
    input  logic [NUM_EVT-1:0] events,
    input  logic               wr_cnt,
    input  logic               wr_lca,
    input  logic               wr_lcb,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   cnt_q,
    output pm_lca_t            lca_q,
    output pm_lcb_t            lcb_q,
    output logic               msb,
    output logic               alert
);
    logic mode_blk;
    logic inc;

    always_comb begin
        mode_blk = user_mode ? lcb_q.mask_u : lcb_q.mask_s;
        inc      = run_en && !lca_q.lfrz && events[lca_q.sel] && !mode_blk;
        msb      = cnt_q[CNT_W-1];
        alert    = msb && lca_q.ce;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lca_q <= '0;
            lcb_q <= '0;
        end else begin
            if (wr_lca) lca_q <= pm_lca_t'(wdata[LCA_W-1:0]);
            if (wr_lcb) lcb_q <= pm_lcb_t'(wdata[LCB_W-1:0]);
        end
    end

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

    // R4
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_cnt) |=> $stable(cnt_q));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_q == $past(wdata));
endmodule

// File: rtl/pmon_bank.sv
`timescale 1ns/1ps
module pmon_bank
    import pmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                user_mode,
    input  logic [HALF_W-1:0]   pmr_first,
    input  logic [HALF_W-1:0]   pmr_second,
    input  logic [CNT_W-1:0]    wdata,
    input  logic [NUM_EVT-1:0]  events,
    output logic [CNT_W-1:0]    rdata,
    output logic                priv_exc,
    output logic                illegal_exc,
    output logic                pm_irq
);
    logic [PMR_W-1:0] pmr_num;
    pm_dec_t          dec;
    logic             rd_ok;
    logic             wr_ok;
    logic             glob_wr;
    logic             ie_q;
    logic             fov_q;
    logic             run_en;
    logic             any_msb;
    logic             any_alert;
    pm_run_e          st, st_nx;

    logic [CNT_W-1:0] cnt_arr [NUM_CNT];
    pm_lca_t          lca_arr [NUM_CNT];
    pm_lcb_t          lcb_arr [NUM_CNT];
    logic [NUM_CNT-1:0] msb_v;
    logic [NUM_CNT-1:0] alert_v;

    assign pmr_num = {pmr_first, pmr_second};

    pmon_decode u_dec (
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .user_mode   (user_mode),
        .pmr_num     (pmr_num),
        .dec         (dec),
        .rd_ok       (rd_ok),
        .wr_ok       (wr_ok),
        .priv_exc    (priv_exc),
        .illegal_exc (illegal_exc)
    );

    assign glob_wr = wr_ok && (dec.region == RG_GLB);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic sel_me;
        assign sel_me = wr_ok && (dec.idx == IDX_W'(g));
        pmon_counter u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_en    (run_en),
            .user_mode (user_mode),
            .events    (events),
            .wr_cnt    (sel_me && (dec.region == RG_CNT)),
            .wr_lca    (sel_me && (dec.region == RG_LCA)),
            .wr_lcb    (sel_me && (dec.region == RG_LCB)),
            .wdata     (wdata),
            .cnt_q     (cnt_arr[g]),
            .lca_q     (lca_arr[g]),
            .lcb_q     (lcb_arr[g]),
            .msb       (msb_v[g]),
            .alert     (alert_v[g])
        );
    end

    assign any_msb   = |msb_v;
    assign any_alert = |alert_v;

    // global enable bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            fov_q <= 1'b0;
        end else if (glob_wr) begin
            ie_q  <= wdata[GLB_IE_BIT];
            fov_q <= wdata[GLB_FOV_BIT];
        end
    end

    // run-state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    // transitions: FREEZE_WR, OVF_TRIP, THAW_WR
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN: begin
                if (glob_wr) begin
                    if (wdata[GLB_FRZ_BIT]) st_nx = ST_HALT;
                end else if (fov_q && any_msb) begin
                    st_nx = ST_HALT;
                end
            end
            ST_HALT: begin
                if (glob_wr && !wdata[GLB_FRZ_BIT]) st_nx = ST_RUN;
            end
            default: st_nx = ST_RUN;
        endcase
    end

    // outputs of the run state
    always_comb begin
        run_en = 1'b0;
        unique case (st)
            ST_RUN:  run_en = !(fov_q && any_msb);
            ST_HALT: run_en = 1'b0;
            default: run_en = 1'b0;
        endcase
        pm_irq = ie_q && any_alert;
    end

    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            unique case (dec.region)
                RG_CNT: rdata = cnt_arr[dec.idx];
                RG_LCA: rdata = CNT_W'(lca_arr[dec.idx]);
                RG_LCB: rdata = CNT_W'(lcb_arr[dec.idx]);
                RG_GLB: begin
                    rdata[GLB_FRZ_BIT] = (st == ST_HALT);
                    rdata[GLB_IE_BIT]  = ie_q;
                    rdata[GLB_FOV_BIT] = fov_q;
                end
                default: rdata = '0;
            endcase
        end
    end

    // R10
    ovf_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && fov_q && any_msb && !glob_wr) |=> st == ST_HALT);

    // R7
    refused_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_exc || illegal_exc) |=> $stable({ie_q, fov_q}));

    // R8
    refused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_exc || illegal_exc) |-> rdata == '0);
endmodule

// File: tb/pmon_bank_tb.sv
`timescale 1ns/1ps
module pmon_bank_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0;
    logic         acc_write = 1'b0;
    logic         user_mode = 1'b0;
    logic [4:0]   pmr_first = '0;
    logic [4:0]   pmr_second = '0;
    logic [31:0]  wdata = '0;
    logic [127:0] events = '0;
    logic [31:0]  rdata;
    logic         priv_exc;
    logic         illegal_exc;
    logic         pm_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_cnt [4];
    logic [31:0] m_lca [4];
    logic [31:0] m_lcb [4];
    logic [31:0] m_glb;

    always #5 clk = ~clk;

    pmon_bank u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .user_mode(user_mode), .pmr_first(pmr_first), .pmr_second(pmr_second),
        .wdata(wdata), .events(events), .rdata(rdata), .priv_exc(priv_exc),
        .illegal_exc(illegal_exc), .pm_irq(pm_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_sup(input int n);
        return (n >= 16 && n < 20) || (n >= 144 && n < 148) || (n >= 288 && n < 292) || n == 400;
    endfunction

    function automatic bit is_usr(input int n);
        return (n >= 0 && n < 4) || (n >= 128 && n < 132) || (n >= 272 && n < 276) || n == 384;
    endfunction

    function automatic logic [31:0] exp_val(input int n);
        int m;
        m = is_usr(n) ? n + 16 : n;
        if (m >= 16 && m < 20)   return m_cnt[m-16];
        if (m >= 144 && m < 148) return m_lca[m-144];
        if (m >= 288 && m < 292) return m_lcb[m-288];
        if (m == 400)            return m_glb;
        return 32'h0;
    endfunction

    function automatic logic [127:0] ev(input int i);
        return 128'(1) << (10 * i + 3);
    endfunction

    task automatic acc(input int n, input bit wr, input bit um, input logic [31:0] d,
                       output logic [31:0] rd, output bit pe, output bit ie);
        logic [9:0] nv;
        @(negedge clk);
        nv = 10'(n);
        acc_valid = 1'b1; acc_write = wr; user_mode = um;
        pmr_first = nv[9:5]; pmr_second = nv[4:0]; wdata = d;
        #1;
        rd = rdata; pe = priv_exc; ie = illegal_exc;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0; user_mode = 1'b0;
    endtask

    task automatic wr_reg(input int n, input logic [31:0] d);
        logic [31:0] rd; bit pe, ie;
        acc(n, 1'b1, 1'b0, d, rd, pe, ie);
    endtask

    task automatic rd_reg(input int n, output logic [31:0] v);
        bit pe, ie;
        acc(n, 1'b0, 1'b0, 32'h0, v, pe, ie);
    endtask

    task automatic run_ev(input logic [127:0] vec, input int cycles, input bit um);
        @(negedge clk);
        user_mode = um; events = vec;
        repeat (cycles) @(negedge clk);
        events = '0; user_mode = 1'b0;
    endtask

    task automatic chk_counters(input string req);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd_reg(16 + i, v);
            chk(req, v, m_cnt[i]);
        end
    endtask

    task automatic chk_all(input string req);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd_reg(16 + i, v);  chk(req, v, m_cnt[i]);
            rd_reg(144 + i, v); chk(req, v, m_lca[i]);
            rd_reg(288 + i, v); chk(req, v, m_lcb[i]);
        end
        rd_reg(400, v); chk(req, v, m_glb);
    endtask

    task automatic set_lca(input int i, input logic [31:0] d);
        wr_reg(144 + i, d); m_lca[i] = d;
    endtask

    task automatic set_cnt(input int i, input logic [31:0] d);
        wr_reg(16 + i, d); m_cnt[i] = d;
    endtask

    task automatic set_glb(input logic [31:0] d);
        wr_reg(400, d); m_glb = d;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit pe, ie;
        logic [127:0] pats [4];
        int cyc [4];

        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 0; m_lca[i] = 0; m_lcb[i] = 0;
        end
        m_glb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 irq", 32'(pm_irq), 0);
        chk("R1 flags", {30'h0, priv_exc, illegal_exc}, 0);
        chk_all("R1 reset value");

        // R2 configure through supervisor numbers and read back
        for (int i = 0; i < 4; i++) begin
            set_lca(i, 32'(10 * i + 3));
            set_cnt(i, 32'(100 * i + 7));
        end
        chk_all("R2 readback");

        // R3 several event patterns
        pats[0] = ev(0);         cyc[0] = 5;
        pats[1] = ev(0) | ev(2); cyc[1] = 3;
        pats[2] = ev(0) | ev(1) | ev(2) | ev(3); cyc[2] = 7;
        pats[3] = ev(1) | ev(3) | 128'(1) << 100; cyc[3] = 2;
        for (int p = 0; p < 4; p++) begin
            run_ev(pats[p], cyc[p], 1'b0);
            for (int i = 0; i < 4; i++)
                if (pats[p] & ev(i)) m_cnt[i] = m_cnt[i] + 32'(cyc[p]);
            chk_counters("R3 event count");
        end

        // R4 local freeze on counter 1
        set_lca(1, m_lca[1] | 32'h80);
        run_ev(ev(0) | ev(1) | ev(2) | ev(3), 4, 1'b0);
        m_cnt[0] += 4; m_cnt[2] += 4; m_cnt[3] += 4;
        chk_counters("R4 local freeze");
        set_lca(1, m_lca[1] & ~32'h80);
        // R4 global freeze
        set_glb(32'h1);
        run_ev(ev(0) | ev(1) | ev(2) | ev(3), 5, 1'b0);
        chk_counters("R4 global freeze");
        rd_reg(400, v); chk("R4 freeze readback", v, 32'h1);
        set_glb(32'h0);

        // R5 mode masks on counter 2
        wr_reg(290, 32'h1); m_lcb[2] = 32'h1;
        run_ev(ev(0) | ev(2), 3, 1'b0);
        m_cnt[0] += 3;
        chk_counters("R5 supervisor mask");
        run_ev(ev(0) | ev(2), 3, 1'b1);
        m_cnt[0] += 3; m_cnt[2] += 3;
        chk_counters("R5 supervisor mask, user mode counts");
        wr_reg(290, 32'h2); m_lcb[2] = 32'h2;
        run_ev(ev(2), 4, 1'b1);
        chk_counters("R5 user mask");
        run_ev(ev(2), 4, 1'b0);
        m_cnt[2] += 4;
        chk_counters("R5 user mask, supervisor counts");
        wr_reg(290, 32'h0); m_lcb[2] = 32'h0;

        // R6 R7 R8 read sweep over every number in both modes
        for (int um = 0; um < 2; um++) begin
            for (int n = 0; n < 1024; n++) begin
                bit epe, eie;
                logic [31:0] ed;
                acc(n, 1'b0, um[0], 32'h0, v, pe, ie);
                epe = um[0] && is_sup(n);
                eie = !is_sup(n) && !is_usr(n);
                ed  = (epe || eie) ? 32'h0 : exp_val(n);
                chk("R7 R8 read flags", {30'h0, pe, ie}, {30'h0, epe, eie});
                chk("R6 read data", v, ed);
            end
        end

        // R7 R8 write sweep: nothing may land
        for (int n = 0; n < 1024; n++) begin
            acc(n, 1'b1, 1'b1, 32'hFFFF_FFFF, v, pe, ie);
            chk("R7 user write flags", {30'h0, pe, ie},
                {30'h0, is_sup(n), !is_sup(n)});
        end
        for (int n = 0; n < 1024; n++) begin
            if (!is_sup(n)) begin
                acc(n, 1'b1, 1'b0, 32'hFFFF_FFFF, v, pe, ie);
                chk("R8 refused write flags", {30'h0, pe, ie}, 32'h1);
            end
        end
        chk_all("R7 R8 state unchanged");

        // R9 interrupt request
        set_lca(0, m_lca[0] | 32'h100);
        set_glb(32'h2);
        set_cnt(0, 32'h7FFF_FFFE);
        #1; chk("R9 irq low below", 32'(pm_irq), 0);
        run_ev(ev(0), 1, 1'b0); m_cnt[0] += 1;
        #1; chk("R9 irq low at max positive", 32'(pm_irq), 0);
        run_ev(ev(0), 1, 1'b0); m_cnt[0] += 1;
        #1; chk("R9 irq high", 32'(pm_irq), 1);
        chk_counters("R9 counter value");
        set_glb(32'h0);
        #1; chk("R9 irq gated by enable", 32'(pm_irq), 0);
        set_glb(32'h2);
        set_cnt(0, 32'h5);
        #1; chk("R9 irq cleared by write", 32'(pm_irq), 0);
        set_cnt(3, 32'h8000_0000);
        #1; chk("R9 no condition enable", 32'(pm_irq), 0);
        set_cnt(3, 32'h7);

        // R10 freeze on overflow
        set_glb(32'h6);
        set_cnt(1, 32'h7FFF_FFFF);
        run_ev(ev(0) | ev(1), 4, 1'b0);
        m_cnt[0] += 1; m_cnt[1] = 32'h8000_0000;
        chk_counters("R10 stop after overflow");
        rd_reg(400, v); chk("R10 freeze-all set", v, 32'h7);
        set_cnt(1, 32'h0);
        set_glb(32'h6);
        run_ev(ev(0), 2, 1'b0); m_cnt[0] += 2;
        chk_counters("R10 resume after clear");
        set_glb(32'h0);

        // R11 write wins over event in the same cycle
        @(negedge clk);
        events = ev(2);
        acc_valid = 1'b1; acc_write = 1'b1; user_mode = 1'b0;
        pmr_first = 5'd0; pmr_second = 5'd18; wdata = 32'h1234;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; events = '0;
        m_cnt[2] = 32'h1234;
        chk_counters("R11 write precedence");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule